// File: doc/BRIEF.md
# Key Matrix Scanner with Frame-Latched Capture

This block scans a key matrix of source lines and return inputs. Within each key slot of the display timing it drives exactly one source line high and records the levels on the return inputs. The slot itself is marked by a level strobe from the scan timer. The source lines are shared with segment drive, so they are asserted only while the slot is open. Outside the slot they are released to the segment path. Successive slots step through the sources in order. With the default sixteen sources, a full pass takes sixteen slots, which is two display frames of eight slots each.

The results collect in a working buffer. When the slot for the final source closes, the whole 32-bit key image is copied into the output register in a single cycle. A serial reader that pulls the four bytes out, bit 0 first, therefore never sees a mix of two scans. When the scan enable is low (the display is off), scanning stops. A scan that was partly done is abandoned and the last published image is kept.

Top module: `key_scan_capture`

## Requirements
- R1: After reset `srcDrive` is all zero and `keyImage` is all zero.
- R2: While `keySlot` and `scanEn` are both high, exactly one bit of `srcDrive` is high. In every other cycle `srcDrive` is all zero.
- R3: The driven source advances by one per completed slot, from source 1 (`srcDrive` bit 0) to source 16 (bit 15). After source 16 it wraps to source 1.
- R4: The value recorded for a slot is the level on `keyRet` in the last cycle in which `keySlot` was high. Levels before that cycle or after the slot closes have no effect.
- R5: Bit 2*(s-1) of `keyImage` holds return input 0 for source s, and bit 2*(s-1)+1 holds return input 1. Byte k is bits 8k+7..8k, so byte 0 covers sources 1 to 4 and byte 3 covers sources 13 to 16. Bit 0 of each byte is the first bit read out.
- R6: `keyImage` changes only on the clock edge that follows the close of the slot for source 16. All 32 bits are replaced together. Between such edges the image holds.
- R7: While `scanEn` is low, no source is driven and the next scan starts at source 1. The published image keeps its value.
- R8: A slot during which `scanEn` falls is not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| scanEn | input | 1 | Scan enable, low while the display is off |
| keySlot | input | 1 | High for the duration of a key slot |
| keyRet | input | NUM_RET | Key return inputs |
| srcDrive | output | NUM_SRC | One-hot source drive, active only in the slot |
| keyImage | output | NUM_SRC*NUM_RET | Latched key image, byte k in bits 8k+7..8k |

## Verification
If the source index is wrong, it shows at once on `srcDrive` in the very next slot as a line out of order. A bad wrap shows within one scan. If the working buffer or the sampling register holds a wrong value, nothing appears until the close of the sixteenth slot. At that point the published image differs from the pattern that was pressed. A bad publish condition shows either as an image change partway through a scan, which the scoreboard catches as an unexpected update, or as an expected image that never arrives.

// File: rtl/kms_pkg.sv
package kms_pkg;
  // Control strobes from sequencer to datapath
  typedef struct packed {
    logic hold;     // slot open: track return levels
    logic commit;   // slot just closed: store tracked levels
    logic publish;  // closing slot was the last source
  } kmsStrobe_t;
endpackage

// File: rtl/kms_ctrl.sv
module kms_ctrl
  import kms_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               scanEn,
  input  logic               keySlot,
  output logic [IDX_W-1:0]   srcIdx,
  output logic [NUM_SRC-1:0] srcDrive,
  output kmsStrobe_t         strobe
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(NUM_SRC - 1);

  logic slotOn;
  logic slotQ;
  logic commit;

  assign slotOn = keySlot & scanEn;
  assign commit = slotQ & ~slotOn & scanEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotQ  <= 1'b0;
      srcIdx <= '0;
    end else begin
      slotQ <= slotOn;
      if (!scanEn)
        srcIdx <= '0;
      else if (commit)
        srcIdx <= (srcIdx == LastIdx) ? '0 : srcIdx + 1'b1;
    end
  end

  assign strobe.hold    = slotOn;
  assign strobe.commit  = commit;
  assign strobe.publish = commit & (srcIdx == LastIdx);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_drive
    assign srcDrive[g] = slotOn & (srcIdx == IDX_W'(g));
  end

  // R7: a disabled scan restarts at the first source
  p_restart_on_disable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !scanEn |=> srcIdx == '0);

  // R2: at most one source line driven
  p_single_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcDrive));

  // R3: index moves only when a slot closes
  p_index_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (scanEn && !commit) |=> $stable(srcIdx));
endmodule

// File: rtl/kms_datapath.sv
module kms_datapath
  import kms_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_RET = 2,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  kmsStrobe_t                 strobe,
  input  logic [IDX_W-1:0]           srcIdx,
  input  logic [NUM_RET-1:0]         keyRet,
  output logic [NUM_SRC*NUM_RET-1:0] keyImage
);
  localparam int ImgW = NUM_SRC * NUM_RET;

  logic [NUM_RET-1:0] retHold;
  logic [ImgW-1:0]    shadow;
  logic [ImgW-1:0]    nextShadow;

  always_comb begin
    nextShadow = shadow;
    nextShadow[int'(srcIdx)*NUM_RET +: NUM_RET] = retHold;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retHold  <= '0;
      shadow   <= '0;
      keyImage <= '0;
    end else begin
      if (strobe.hold)    retHold  <= keyRet;
      if (strobe.commit)  shadow   <= nextShadow;
      if (strobe.publish) keyImage <= nextShadow;
    end
  end

  // R4: tracked return levels frozen once the slot closes
  p_hold_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.hold |=> $stable(retHold));

  // R6: published image moves only on a publish strobe
  p_image_atomic_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.publish |=> $stable(keyImage));
endmodule

// File: rtl/key_scan_capture.sv
module key_scan_capture
  import kms_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_RET = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       scanEn,
  input  logic                       keySlot,
  input  logic [NUM_RET-1:0]         keyRet,
  output logic [NUM_SRC-1:0]         srcDrive,
  output logic [NUM_SRC*NUM_RET-1:0] keyImage
);
  localparam int IdxW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  kmsStrobe_t      strobe;
  logic [IdxW-1:0] srcIdx;

  kms_ctrl #(.NUM_SRC(NUM_SRC), .IDX_W(IdxW)) u_ctrl (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .keySlot(keySlot),
    .srcIdx(srcIdx), .srcDrive(srcDrive), .strobe(strobe)
  );

  kms_datapath #(.NUM_SRC(NUM_SRC), .NUM_RET(NUM_RET), .IDX_W(IdxW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcIdx(srcIdx),
    .keyRet(keyRet), .keyImage(keyImage)
  );

  // R2: no drive outside an enabled slot
  p_no_drive_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(keySlot && scanEn) |-> srcDrive == '0);
endmodule

// File: tb/key_scan_capture_bench.sv
module key_scan_capture_bench;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        scanEn = 1'b0;
  logic        keySlot = 1'b0;
  logic [1:0]  keyRet = 2'b00;
  logic [15:0] srcDrive;
  logic [31:0] keyImage;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int curIdx = 0;
  logic [31:0] expQ[$];
  logic [31:0] lastSeen = '0;
  logic [31:0] lastPub = '0;

  always #(ClkPeriod/2) clk = ~clk;

  key_scan_capture u_key_scan_capture (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .keySlot(keySlot),
    .keyRet(keyRet), .srcDrive(srcDrive), .keyImage(keyImage)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: every image change must match the next queued expectation
  always @(negedge clk) begin
    if (rstN && keyImage !== lastSeen) begin
      if (expQ.size() == 0) begin
        check("R6 unexpected update", keyImage, lastSeen);
      end else begin
        check("R5 R6 published image", keyImage, expQ.pop_front());
      end
      lastSeen = keyImage;
    end
  end

  // One key slot; noisy returns before the last slot cycle test R4
  task automatic doSlot(input logic [1:0] ret, input int len, input bit noisy);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      keySlot = 1'b1;
      keyRet  = (noisy && i < len - 1) ? ~ret : ret;
      if (i == 0) begin
        #1;
        check("R2 R3 source drive in slot", 32'(srcDrive), 32'(16'(1) << curIdx));
      end
    end
    @(negedge clk);
    keySlot = 1'b0;
    keyRet  = ~ret;
    if (curIdx == 15) begin
      expQ.push_back(lastPub);
    end
    curIdx = (curIdx + 1) % 16;
    #1;
    check("R2 no drive after slot", 32'(srcDrive), 32'h0);
  endtask

  task automatic doScan(input logic [31:0] pat, input bit noisy);
    lastPub = pat;
    for (int s = 0; s < 16; s++) begin
      doSlot(pat[2*s +: 2], 2 + (s % 3), noisy);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset srcDrive", 32'(srcDrive), 32'h0);
    check("R1 reset keyImage", keyImage, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    // R7 disabled: a slot drives nothing
    keySlot = 1'b1;
    #1 check("R7 no drive while disabled", 32'(srcDrive), 32'h0);
    @(negedge clk);
    keySlot = 1'b0;
    scanEn = 1'b1;
    @(negedge clk);

    // R5 packing: only source 5, return 1 pressed -> byte 1 bit 1
    doScan(32'h0000_0200, 1'b0);
    check("R5 byte1 layout", 32'(keyImage[15:8]), 32'h02);
    check("R5 byte0 empty", 32'(keyImage[7:0]), 32'h00);

    // R4 noisy returns, R3 wrap back to source 1
    doScan(32'hA5C3_1E87, 1'b1);
    doScan(32'h8000_0001, 1'b0);
    check("R5 source16 return1 is bit31", 32'(keyImage[31]), 32'h1);
    check("R5 source1 return0 is bit0", 32'(keyImage[0]), 32'h1);

    // R8 R7: partial scan then disable mid-slot
    doSlot(2'b11, 2, 1'b0);
    doSlot(2'b11, 2, 1'b0);
    @(negedge clk);
    keySlot = 1'b1;
    keyRet = 2'b10;
    @(negedge clk);
    scanEn = 1'b0;
    #1 check("R7 R8 drive dropped with enable", 32'(srcDrive), 32'h0);
    @(negedge clk);
    keySlot = 1'b0;
    curIdx = 0;
    repeat (3) @(negedge clk);
    check("R7 image held while disabled", keyImage, 32'h8000_0001);
    scanEn = 1'b1;
    @(negedge clk);

    doScan(32'h0F0F_5A5A, 1'b0);
    check("R6 all expectations consumed", 32'(expQ.size()), 32'h0);
    check("R6 final image", keyImage, 32'h0F0F_5A5A);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(ClkPeriod * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule